// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches a set of external input pins (eight by default) and raises one interrupt request for each channel. Every channel has a two-bit sense code that picks one of four triggers: low level, any change, falling edge or rising edge. Each pin passes through a synchronizer into the system clock domain. Edges are then found by comparing two consecutive synchronized samples. An edge sets a pending flag. Software clears that flag by writing a one, and the interrupt logic clears it with a per-channel acknowledge.

Channels below a configurable boundary (the lower four by default) do not support the any-change code. On those channels the code is reserved and never produces a request. A request reaches `irq_o` only when three conditions hold: the global enable input is high, the channel's mask bit is set, and the channel's trigger condition is true. For an edge mode the trigger condition is the pending flag. For low-level mode it is the synchronized pin being low. Registers are reached through a byte-wide synchronous bus, and reads are combinational.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every control byte, the mask and the flags read 0, and `irq_o` is 0. All channels therefore start in low-level mode and disabled.
- R2: Register map. The control byte at address k holds channels 4k to 4k+3. The field of channel n sits at bits [2(n mod 4)+1 : 2(n mod 4)] of that byte. The mask is at address 2 and the flags are at address 3 (bit n = channel n). Every written value reads back.
- R3: Sense code 00 (low level) drives `irq_o[n]` high two clock edges after the pin falls, and holds it high while the pin stays low and the channel is enabled. In this mode the flag reads 0.
- R4: Sense code 10 (falling): a high-to-low pin change sets flag n on the third rising clock edge after the change.
- R5: Sense code 11 (rising): a low-to-high pin change sets flag n with the same three-edge latency as R4.
- R6: Sense code 01 on channels 4 to 7 sets flag n on every change of the pin, in either direction.
- R7: Sense code 01 on channels 0 to 3 is reserved. Pin changes set no flag and raise no request.
- R8: Writing to the flag address clears each flag whose written bit is 1. A flag whose written bit is 0 is left unchanged.
- R9: A high `ack_i[n]` for one cycle clears flag n.
- R10: When a qualifying edge and an acknowledge (or a clearing write) occur in the same cycle, the flag ends up set.
- R11: `irq_o[n]` equals global enable AND mask bit AND trigger condition. With the global enable low, a flag is still recorded but no request is output.
- R12: Switching a channel with a set flag to low-level mode clears that flag at the next edge.
- R13: A pin that stays high through and after reset produces no edge event once an edge mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_CH | External pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | NUM_CH | Per-channel service acknowledge |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | NUM_CH | Per-channel interrupt request |

## Verification
Each kind of internal fault shows up at the ports within a fixed number of cycles:
- A corrupted edge history produces a false or missing flag three edges after the pin event. That flag is visible on the flag register and, when enabled, on `irq_o`.
- A stuck or wrongly cleared flag diverges from the reference model at the first edge after the write, acknowledge or mode change that should have moved it.
- A wrong synchronizer depth shifts level requests and flag timing by whole cycles.

The bench compares against its reference model every clock, so any of these faults is flagged at the first differing cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int SENSE_W = 2;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   // No reset: the chain only carries pin state; downstream history follows it
   always_ff @(posedge clk) begin
      stage_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
   import eirq_pkg::*;
#(
   parameter bit HAS_ANY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_i,
   input  logic [SENSE_W-1:0] mode_i,
   input  logic               en_i,
   input  logic               gie_i,
   input  logic               ack_i,
   input  logic               clr_i,
   output logic               flag_o,
   output logic               irq_o
);
   sense_e mode;
   logic   prev_q;
   logic   flag_q;
   logic   any_chg;
   logic   evt;

   assign mode = sense_e'(mode_i);

   // History follows the synchronized pin in reset too, so no edge appears at release
   always_ff @(posedge clk) begin
      prev_q <= pin_i;
   end

   if (HAS_ANY) begin : g_any
      assign any_chg = prev_q ^ pin_i;
   end else begin : g_rsvd
      assign any_chg = 1'b0;
   end

   always_comb begin
      unique case (mode)
         SENSE_FALL: evt = prev_q & ~pin_i;
         SENSE_RISE: evt = ~prev_q & pin_i;
         SENSE_ANY:  evt = any_chg;
         default:    evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (mode == SENSE_LOW) begin
         flag_q <= 1'b0;
      end else if (evt) begin
         flag_q <= 1'b1;
      end else if (ack_i || clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = gie_i & en_i & ((mode == SENSE_LOW) ? ~pin_i : flag_q);

   AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SENSE_LOW) |=> !flag_o); // R12
   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && mode != SENSE_LOW) |=> flag_o); // R10
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !evt) |=> !flag_o); // R9
   if (!HAS_ANY) begin : g_rsvd_chk
      AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == SENSE_ANY && !flag_o) |=> !flag_o); // R7
   end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
   import eirq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sel_i,
   input  logic                      we_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic [NUM_CH-1:0]         flags_i,
   output logic [DATA_W-1:0]         rdata_o,
   output logic [SENSE_W*NUM_CH-1:0] ctrl_o,
   output logic [NUM_CH-1:0]         mask_o,
   output logic [NUM_CH-1:0]         clr_o
);
   localparam int CTRL_BITS = SENSE_W * NUM_CH;
   localparam int CTRL_REGS = CTRL_BITS / DATA_W;
   localparam int MASK_ADDR = CTRL_REGS;
   localparam int FLAG_ADDR = CTRL_REGS + 1;

   if (CTRL_BITS % DATA_W != 0) begin : g_bad_pack
      $error("eirq_regs: control fields must fill whole bytes");
   end
   if ((1 << ADDR_W) < CTRL_REGS + 2) begin : g_bad_addr
      $error("eirq_regs: ADDR_W too small for the register map");
   end

   logic [CTRL_BITS-1:0] ctrl_q;
   logic [NUM_CH-1:0]    mask_q;
   logic                 wr;

   assign wr = sel_i & we_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
      end else if (wr) begin
         for (int k = 0; k < CTRL_REGS; k++) begin
            if (addr_i == ADDR_W'(k)) ctrl_q[k*DATA_W +: DATA_W] <= wdata_i;
         end
         if (addr_i == ADDR_W'(MASK_ADDR)) mask_q <= wdata_i[NUM_CH-1:0];
      end
   end

   assign clr_o = (wr && addr_i == ADDR_W'(FLAG_ADDR)) ? wdata_i[NUM_CH-1:0] : '0;

   always_comb begin
      rdata_o = '0;
      for (int k = 0; k < CTRL_REGS; k++) begin
         if (addr_i == ADDR_W'(k)) rdata_o = ctrl_q[k*DATA_W +: DATA_W];
      end
      if (addr_i == ADDR_W'(MASK_ADDR)) rdata_o[NUM_CH-1:0] = mask_q;
      if (addr_i == ADDR_W'(FLAG_ADDR)) rdata_o[NUM_CH-1:0] = flags_i;
   end

   assign ctrl_o = ctrl_q;
   assign mask_o = mask_q;

   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr_i == ADDR_W'(MASK_ADDR)) |=> $stable(mask_o)); // R2
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import eirq_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int LOW_GROUP   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_i,
   input  logic              gie_i,
   input  logic [NUM_CH-1:0] ack_i,
   input  logic              bus_sel_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);
   if (NUM_CH > DATA_W) begin : g_bad_ch
      $error("ext_irq_ctrl: NUM_CH exceeds the bus width");
   end
   if (LOW_GROUP > NUM_CH) begin : g_bad_group
      $error("ext_irq_ctrl: LOW_GROUP exceeds NUM_CH");
   end

   logic [NUM_CH-1:0]         pin_s;
   logic [SENSE_W*NUM_CH-1:0] ctrl;
   logic [NUM_CH-1:0]         mask;
   logic [NUM_CH-1:0]         clr;
   logic [NUM_CH-1:0]         flags;

   eirq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d_i (pin_i),
      .q_o (pin_s)
   );

   eirq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (bus_sel_i),
      .we_i    (bus_we_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .flags_i (flags),
      .rdata_o (bus_rdata_o),
      .ctrl_o  (ctrl),
      .mask_o  (mask),
      .clr_o   (clr)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      eirq_chan #(.HAS_ANY(n >= LOW_GROUP)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_s[n]),
         .mode_i (ctrl[n*SENSE_W +: SENSE_W]),
         .en_i   (mask[n]),
         .gie_i  (gie_i),
         .ack_i  (ack_i[n]),
         .clr_i  (clr[n]),
         .flag_o (flags[n]),
         .irq_o  (irq_o[n])
      );
   end

   AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> (irq_o == '0)); // R11
   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_o & ~mask) == '0)); // R11
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin = 8'hFF;
   logic       gie = 1'b0;
   logic [7:0] ack = 8'h00;
   logic       sel = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [7:0] irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ext_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .gie_i(gie), .ack_i(ack),
      .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: pin history queue plus per-channel register model
   logic [7:0]  hist[$] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
   logic [15:0] m_ctrl = '0;
   logic [7:0]  m_mask = '0;
   logic [7:0]  m_flag = '0;

   always @(posedge clk) begin
      logic [7:0] nf;
      hist.push_front(pin);
      if (hist.size() > 4) void'(hist.pop_back());
      if (!rst_n) begin
         m_ctrl = '0; m_mask = '0; m_flag = '0;
      end else begin
         for (int n = 0; n < 8; n++) begin
            int  code;
            bit  cur, old, ev, wclr;
            code = int'(m_ctrl[2*n +: 2]);
            cur  = hist[2][n];
            old  = hist[3][n];
            ev   = (code == 2) ? (old && !cur) :
                   (code == 3) ? (!old && cur) :
                   (code == 1 && n >= 4) ? (cur != old) : 1'b0;
            wclr = sel && we && addr == 2'd3 && wdata[n];
            if (code == 0) nf[n] = 1'b0;
            else if (ev) nf[n] = 1'b1;
            else if (ack[n] || wclr) nf[n] = 1'b0;
            else nf[n] = m_flag[n];
         end
         m_flag = nf;
         if (sel && we) begin
            if (addr == 2'd0) m_ctrl[7:0] = wdata;
            if (addr == 2'd1) m_ctrl[15:8] = wdata;
            if (addr == 2'd2) m_mask = wdata;
         end
      end
   end

   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         logic [7:0] ei, er;
         for (int n = 0; n < 8; n++) begin
            bit trig;
            trig = (m_ctrl[2*n +: 2] == 2'b00) ? !hist[1][n] : m_flag[n];
            ei[n] = gie && m_mask[n] && trig;
         end
         case (addr)
            2'd0: er = m_ctrl[7:0];
            2'd1: er = m_ctrl[15:8];
            2'd2: er = m_mask;
            default: er = m_flag;
         endcase
         chk("R11 model irq", 32'(irq), 32'(ei));
         chk("R2 model rdata", 32'(rdata), 32'(er));
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk); sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
   endtask

   task automatic setup(input logic [1:0] ca, input logic [7:0] cv, input logic [7:0] m);
      wr(2'd2, 8'h00);
      wr(ca, cv);
      wr(2'd3, 8'hFF);
      wr(2'd2, m);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      // R1
      rd(2'd0, v); chk("R1 ctrl0", 32'(v), 0);
      rd(2'd1, v); chk("R1 ctrl1", 32'(v), 0);
      rd(2'd2, v); chk("R1 mask", 32'(v), 0);
      rd(2'd3, v); chk("R1 flags", 32'(v), 0);
      chk("R1 irq", 32'(irq), 0);
      // R2 readback
      wr(2'd0, 8'hA5); rd(2'd0, v); chk("R2 ctrl0", 32'(v), 32'hA5);
      wr(2'd1, 8'h3C); rd(2'd1, v); chk("R2 ctrl1", 32'(v), 32'h3C);
      wr(2'd2, 8'h5A); rd(2'd2, v); chk("R2 mask", 32'(v), 32'h5A);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      gie = 1'b1;
      // R4 falling on channel 5 (ctrl1 bits 3:2 = 10)
      setup(2'd1, 8'h08, 8'h20);
      @(negedge clk); pin[5] = 1'b0;
      cyc(2); chk("R4 not yet", 32'(irq[5]), 0);
      cyc(1); chk("R4 irq", 32'(irq[5]), 1);
      rd(2'd3, v); chk("R4 flag", 32'(v), 32'h20);
      // R11 global enable
      @(negedge clk); gie = 1'b0;
      #1 chk("R11 gie off", 32'(irq), 0);
      rd(2'd3, v); chk("R11 flag kept", 32'(v), 32'h20);
      @(negedge clk); gie = 1'b1;
      // R8 write one to clear
      wr(2'd3, 8'hDF); rd(2'd3, v); chk("R8 zero no effect", 32'(v), 32'h20);
      wr(2'd3, 8'h20); rd(2'd3, v); chk("R8 one clears", 32'(v), 0);
      // R5 rising on channel 5, R9 acknowledge
      setup(2'd1, 8'h0C, 8'h20);
      @(negedge clk); pin[5] = 1'b1;
      cyc(3); rd(2'd3, v); chk("R5 flag", 32'(v), 32'h20);
      @(negedge clk); ack = 8'h20;
      @(negedge clk); ack = 8'h00;
      rd(2'd3, v); chk("R9 ack clears", 32'(v), 0);
      // R6 any change on channel 6 (ctrl1 bits 5:4 = 01)
      setup(2'd1, 8'h10, 8'h40);
      @(negedge clk); pin[6] = 1'b0;
      cyc(3); rd(2'd3, v); chk("R6 fall", 32'(v), 32'h40);
      wr(2'd3, 8'h40);
      @(negedge clk); pin[6] = 1'b1;
      cyc(3); rd(2'd3, v); chk("R6 rise", 32'(v), 32'h40);
      // R7 reserved code on channel 1 (ctrl0 bits 3:2 = 01)
      setup(2'd0, 8'h04, 8'h02);
      @(negedge clk); pin[1] = 1'b0;
      cyc(4); rd(2'd3, v); chk("R7 fall ignored", 32'(v), 0);
      @(negedge clk); pin[1] = 1'b1;
      cyc(4); rd(2'd3, v); chk("R7 rise ignored", 32'(v), 0);
      chk("R7 irq", 32'(irq[1]), 0);
      // R3 level on channel 2
      setup(2'd0, 8'h00, 8'h04);
      @(negedge clk); pin[2] = 1'b0;
      cyc(1); chk("R3 not yet", 32'(irq[2]), 0);
      cyc(1); chk("R3 level irq", 32'(irq[2]), 1);
      cyc(5); chk("R3 held", 32'(irq[2]), 1);
      rd(2'd3, v); chk("R3 flag zero", 32'(v), 0);
      @(negedge clk); pin[2] = 1'b1;
      cyc(2); chk("R3 released", 32'(irq[2]), 0);
      // R12 switch to level clears flag, channel 3 (ctrl0 bits 7:6)
      setup(2'd0, 8'h80, 8'h08);
      @(negedge clk); pin[3] = 1'b0;
      cyc(3); rd(2'd3, v); chk("R12 flag set", 32'(v), 32'h08);
      wr(2'd0, 8'h00);
      rd(2'd3, v); chk("R12 flag forced", 32'(v), 0);
      @(negedge clk); pin[3] = 1'b1;
      cyc(3);
      // R10 edge and acknowledge together, channel 4 (ctrl1 bits 1:0 = 10)
      setup(2'd1, 8'h02, 8'h10);
      @(negedge clk); pin[4] = 1'b0;
      cyc(2); ack = 8'h10;
      @(negedge clk); ack = 8'h00;
      rd(2'd3, v); chk("R10 edge wins", 32'(v), 32'h10);
      @(negedge clk); pin[4] = 1'b1;
      cyc(3);
      // R13 reset with pins high, then rising mode
      @(negedge clk); rst_n = 1'b0;
      cyc(5); rst_n = 1'b1;
      rd(2'd3, v); chk("R1 flags after reset", 32'(v), 0);
      wr(2'd0, 8'h03); wr(2'd2, 8'h01);
      cyc(6); rd(2'd3, v); chk("R13 no spurious edge", 32'(v), 0);
      chk("R13 irq", 32'(irq[0]), 0);
      cyc(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule